// File: doc/BRIEF.md
# Eight-Level Nested Priority Interrupt Core

This block collects interrupt requests from eight independent lines and decides which one the processor should serve next. Each line is first synchronized into the core clock. It is then captured into a request register, either on a rising transition or for as long as the line is high. A mask register can block each level on its own. An in-service register records the levels whose handlers are running. Line 0 has the highest priority and line 7 the lowest. A request raises the interrupt output only when it is unmasked and ranks above every level currently in service, so handlers nest strictly by priority.

An external acknowledge sequencer drives three one-cycle strobes. The freeze strobe latches the current winner. The acknowledge strobe commits that winner: it sets the winner's in-service bit and clears its request bit. The end-of-interrupt strobe retires the highest-priority level in service. If nothing is eligible when freeze arrives, the core reports level 7 and raises a spurious flag, and the acknowledge that follows changes nothing. An init strobe returns the core to its starting state. It also arms the rising-edge detector so that a line which is already high cannot raise a request.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the request, mask and in-service read-backs are all zero, the interrupt output is low, the reported level is 0 and the spurious flag is low.
- R2: With `level_mode` low, a request bit is set only by a low-to-high change of its line, seen after the synchronizer (a few cycles of latency).
- R3: With `level_mode` low, a request bit clears when its line returns low before the request is acknowledged.
- R4: With `level_mode` high, each request bit follows the level of its synchronized line.
- R5: Mask bit i (`mask_wdata[i]` = 1 means blocked) stops only level i from taking part in arbitration. The request read-back still shows the blocked bit, and lower-priority unmasked levels still raise the interrupt.
- R6: A freeze strobe latches, on `win_level`, the lowest-numbered unmasked request that ranks above every in-service level.
- R7: An acknowledge strobe that follows a freeze with a valid winner sets that level's in-service bit and clears its request bit. An acknowledge with no preceding freeze does nothing.
- R8: `int_out` is high exactly when some unmasked request has a smaller index than every set in-service bit, or when no in-service bit is set and some unmasked request exists.
- R9: An end-of-interrupt strobe clears the lowest-numbered set in-service bit and leaves the other in-service bits unchanged.
- R10: A freeze with no eligible request reports level 7 with `win_spurious` high, and the following acknowledge leaves the in-service and request registers unchanged.
- R11: An init strobe clears the request, mask and in-service registers and the latched winner. After init, a line that is already high in edge mode registers nothing until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Asynchronous request lines, bit 0 highest priority |
| level_mode | input | 1 | 1 = level capture, 0 = rising-edge capture |
| init | input | 1 | One-cycle strobe that returns the core to its starting state |
| mask_wr | input | 1 | Loads `mask_wdata` into the mask register |
| mask_wdata | input | 8 | New mask value, 1 blocks the level |
| freeze | input | 1 | Latches the current winner |
| ack | input | 1 | Commits the latched winner into service |
| eoi | input | 1 | Retires the highest-priority in-service level |
| int_out | output | 1 | Interrupt request to the processor |
| win_level | output | 3 | Latched winning level |
| win_spurious | output | 1 | Latched winner was a spurious level 7 |
| irr_q | output | 8 | Request register read-back |
| imr_q | output | 8 | Mask register read-back |
| isr_q | output | 8 | In-service register read-back |

## Verification
The bench targets nesting. When a lower-priority request arrives while a higher level is in service, it must stay silent. A resolver that compared requests only against each other would raise `int_out` there. It then checks that an end-of-interrupt retires only the top in-service bit; clearing all of them, or the wrong one, would unblock the wrong levels. It holds a line high through init in edge mode: a detector that was not re-armed would capture a phantom request. It also freezes with no eligible request and checks that the spurious level 7 is reported and that the following acknowledge is harmless. A design that set in-service bit 7 at that point would block every later request from line 7.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_N  = 8;
  localparam int IRQ_LW = $clog2(IRQ_N);

  typedef logic [IRQ_N-1:0]  irq_vec_t;
  typedef logic [IRQ_LW-1:0] irq_lvl_t;

  localparam irq_lvl_t LVL_SPURIOUS = irq_lvl_t'(IRQ_N - 1);

  // isolate the least significant set bit (highest priority)
  function automatic irq_vec_t lowest_bit(irq_vec_t v);
    return v & irq_vec_t'(~v + irq_vec_t'(1));
  endfunction

  // index of the least significant set bit, 0 when empty
  function automatic irq_lvl_t bit_index(irq_vec_t v);
    irq_lvl_t idx;
    idx = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (v[i]) idx = irq_lvl_t'(i);
    end
    return idx;
  endfunction

  // levels strictly above the top in-service level; all when none in service
  function automatic irq_vec_t above_service(irq_vec_t isr);
    return irq_vec_t'(lowest_bit(isr) - irq_vec_t'(1));
  endfunction

  function automatic irq_vec_t level_bit(irq_lvl_t l);
    return irq_vec_t'(1) << l;
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t irq_in,
  input  logic     level_mode,
  input  logic     init,
  input  irq_vec_t ack_clr,
  output irq_vec_t irr_q
);
  irq_vec_t stage_q [SYNC_STAGES];
  irq_vec_t line_s;
  irq_vec_t prev_q;
  irq_vec_t rise_w;
  irq_vec_t irr_next;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= irq_in;
        else stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign line_s = stage_q[SYNC_STAGES-1];
  assign rise_w = line_s & ~prev_q;

  always_comb begin
    if (level_mode) irr_next = line_s;
    else            irr_next = (irr_q & line_s) | rise_w;
    irr_next = irr_next & ~ack_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      irr_q  <= '0;
    end else if (init) begin
      prev_q <= '1;
      irr_q  <= '0;
    end else begin
      prev_q <= line_s;
      irr_q  <= irr_next;
    end
  end

  // R3/R4: a request bit can only be held while its synchronized line was high
  a_r3_irr_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr_q & ~$past(line_s)) == '0));
  // R11: init empties the request register
  a_r11_init_irr: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (irr_q == '0));
  // R2: in edge mode a new bit needs a rise on the line
  a_r2_edge_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !init) |=> ((irr_q & ~$past(irr_q) & $past(prev_q)) == '0));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t irr_q,
  input  irq_vec_t imr_q,
  input  irq_vec_t isr_q,
  output logic     int_req,
  output irq_lvl_t best_lvl
);
  irq_vec_t open_req;
  irq_vec_t eligible;

  assign open_req = irr_q & ~imr_q;
  assign eligible = open_req & above_service(isr_q);
  assign int_req  = |eligible;
  assign best_lvl = bit_index(eligible);

  // R5: with every request masked, the interrupt stays low
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & ~imr_q) == '0) |-> !int_req);
  // R8: a level equal to or below the top in-service level never wins
  a_r8_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && (isr_q != '0)) |-> (best_lvl < bit_index(isr_q)));
endmodule

// File: rtl/irq_service.sv
module irq_service
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     init,
  input  logic     mask_wr,
  input  irq_vec_t mask_wdata,
  input  logic     freeze,
  input  logic     ack,
  input  logic     eoi,
  input  logic     int_req,
  input  irq_lvl_t best_lvl,
  output irq_vec_t imr_q,
  output irq_vec_t isr_q,
  output irq_lvl_t win_q,
  output logic     spur_q,
  output irq_vec_t ack_clr
);
  logic     pend_q;
  logic     ack_go;
  irq_vec_t set_bit;
  irq_vec_t retire_bit;

  assign ack_go     = ack && pend_q && !spur_q;
  assign set_bit    = ack_go ? level_bit(win_q) : '0;
  assign retire_bit = eoi ? lowest_bit(isr_q) : '0;
  assign ack_clr    = set_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q  <= '0;
      isr_q  <= '0;
      win_q  <= '0;
      spur_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (init) begin
      imr_q  <= '0;
      isr_q  <= '0;
      win_q  <= '0;
      spur_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (mask_wr) imr_q <= mask_wdata;
      isr_q <= (isr_q & ~retire_bit) | set_bit;
      if (freeze) begin
        win_q  <= int_req ? best_lvl : LVL_SPURIOUS;
        spur_q <= !int_req;
        pend_q <= 1'b1;
      end else if (ack) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R7: a committed acknowledge leaves the winner in service
  a_r7_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_go && !init && !freeze) |=> isr_q[win_q]);
  // R9: end-of-interrupt retires exactly one level
  a_r9_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_go && !init && (isr_q != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
  // R10: a freeze with nothing eligible reports the spurious level
  a_r10_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !int_req && !init) |=> (spur_q && (win_q == LVL_SPURIOUS)));
  // R11: init empties mask and in-service state
  a_r11_init_svc: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> ((imr_q == '0) && (isr_q == '0) && !spur_q));
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IRQ_N-1:0]       irq_in,
  input  logic                   level_mode,
  input  logic                   init,
  input  logic                   mask_wr,
  input  logic [IRQ_N-1:0]       mask_wdata,
  input  logic                   freeze,
  input  logic                   ack,
  input  logic                   eoi,
  output logic                   int_out,
  output logic [IRQ_LW-1:0]      win_level,
  output logic                   win_spurious,
  output logic [IRQ_N-1:0]       irr_q,
  output logic [IRQ_N-1:0]       imr_q,
  output logic [IRQ_N-1:0]       isr_q
);
  irq_vec_t ack_clr;
  irq_lvl_t best_lvl;
  logic     int_req;

  irq_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .init(init), .ack_clr(ack_clr), .irr_q(irr_q)
  );

  irq_resolver u_resolver (
    .clk(clk), .rst_n(rst_n), .irr_q(irr_q), .imr_q(imr_q), .isr_q(isr_q),
    .int_req(int_req), .best_lvl(best_lvl)
  );

  irq_service u_service (
    .clk(clk), .rst_n(rst_n), .init(init), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .freeze(freeze), .ack(ack), .eoi(eoi),
    .int_req(int_req), .best_lvl(best_lvl), .imr_q(imr_q), .isr_q(isr_q),
    .win_q(win_level), .spur_q(win_spurious), .ack_clr(ack_clr)
  );

  assign int_out = int_req;

  // R1: nothing is requested or in service right after reset release
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (isr_q == '0));
endmodule

// File: tb/irq_prio_core_tb_top.sv
module irq_prio_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       level_mode = 1'b0;
  logic       init = 1'b0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       freeze = 1'b0;
  logic       ack = 1'b0;
  logic       eoi = 1'b0;
  logic       int_out;
  logic [2:0] win_level;
  logic       win_spurious;
  logic [7:0] irr_q, imr_q, isr_q;

  int n_checks = 0;
  int n_fail = 0;

  logic [7:0] m_irr = '0, m_imr = '0, m_isr = '0, m_prev = '0;
  logic [2:0] m_win = '0;
  logic       m_spur = 1'b0;

  always #10 clk = ~clk;

  irq_prio_core dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .init(init), .mask_wr(mask_wr), .mask_wdata(mask_wdata), .freeze(freeze),
    .ack(ack), .eoi(eoi), .int_out(int_out), .win_level(win_level),
    .win_spurious(win_spurious), .irr_q(irr_q), .imr_q(imr_q), .isr_q(isr_q)
  );

  // top in-service index, 8 when none
  function automatic int top_service(logic [7:0] s);
    for (int i = 0; i < 8; i++) if (s[i]) return i;
    return 8;
  endfunction

  function automatic int pick(logic [7:0] r, logic [7:0] m, logic [7:0] s);
    int lim;
    lim = top_service(s);
    for (int i = 0; i < lim; i++) if (r[i] && !m[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " R2/R3/R4 irr"}, 32'(irr_q), 32'(m_irr));
    check({tag, " R5 imr"}, 32'(imr_q), 32'(m_imr));
    check({tag, " R7/R9 isr"}, 32'(isr_q), 32'(m_isr));
    check({tag, " R8 int"}, 32'(int_out), 32'(pick(m_irr, m_imr, m_isr) >= 0));
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic drive_lines(logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    if (level_mode) m_irr = v;
    else m_irr = (m_irr & v) | (v & ~m_prev);
    m_prev = v;
    settle();
  endtask

  task automatic write_mask(logic [7:0] v);
    @(negedge clk);
    mask_wr = 1'b1; mask_wdata = v;
    @(negedge clk);
    mask_wr = 1'b0;
    m_imr = v;
    settle();
  endtask

  task automatic ack_cycle(string tag);
    int w;
    w = pick(m_irr, m_imr, m_isr);
    @(negedge clk); freeze = 1'b1;
    @(negedge clk); freeze = 1'b0; ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    if (w < 0) begin
      m_win = 3'd7; m_spur = 1'b1;
    end else begin
      m_win = 3'(w); m_spur = 1'b0;
      m_isr[w] = 1'b1;
      m_irr[w] = level_mode ? irq_in[w] : 1'b0;
    end
    settle();
    check({tag, " R6/R10 level"}, 32'(win_level), 32'(m_win));
    check({tag, " R10 spurious"}, 32'(win_spurious), 32'(m_spur));
    check_all(tag);
  endtask

  task automatic end_of_irq();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
    for (int i = 0; i < 8; i++) if (m_isr[i]) begin m_isr[i] = 1'b0; break; end
    settle();
  endtask

  task automatic do_init();
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    m_irr = level_mode ? irq_in : 8'h00;
    m_imr = '0; m_isr = '0; m_prev = irq_in;
    m_win = '0; m_spur = 1'b0;
    settle();
    check("R11 init level", 32'(win_level), 32'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    check("R1 spurious", 32'(win_spurious), 32'(0));
    check("R1 level", 32'(win_level), 32'(0));
    check_all("R1 reset");

    // R2 edge capture, R5 mask keeps lower level alive
    drive_lines(8'h24);
    check_all("R2 rise");
    write_mask(8'h04);
    check_all("R5 masked 2");
    ack_cycle("R6 picks 5 past mask");
    // R8 lower priority blocked by level 5 in service
    drive_lines(8'h64);
    check("R8 blocked by 5", 32'(int_out), 32'(0));
    drive_lines(8'h66);
    check("R8 level 1 preempts", 32'(int_out), 32'(1));
    ack_cycle("R7 nest 1");
    // R9 eoi retires 1 only
    end_of_irq();
    check("R9 eoi keeps 5", 32'(isr_q), 32'(8'h20));
    check_all("R9 after eoi");
    // R3 line drop clears edge request
    drive_lines(8'h04);
    check_all("R3 drop");
    // R10 spurious freeze
    write_mask(8'hFF);
    ack_cycle("R10 spurious");
    end_of_irq();
    // R11 init with line high in edge mode
    drive_lines(8'h80);
    do_init();
    check("R11 held line ignored", 32'(irr_q), 32'(0));
    check_all("R11 init");
    drive_lines(8'h00);
    drive_lines(8'h80);
    check("R2 fresh rise after init", 32'(irr_q), 32'(8'h80));
    // R4 level mode
    level_mode = 1'b1;
    do_init();
    drive_lines(8'h11);
    check("R4 level follow", 32'(irr_q), 32'(8'h11));
    drive_lines(8'h10);
    check_all("R4 level low");

    // random phase
    for (int k = 0; k < 300; k++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 7) begin
        logic [7:0] v;
        v = (r < 4) ? (irq_in ^ (8'h01 << ($urandom % 8))) : 8'($urandom);
        drive_lines(v);
        check_all("R2/R4 random lines");
      end else if (r < 9) begin
        write_mask(8'($urandom & $urandom));
        check_all("R5 random mask");
      end else if (r < 15) begin
        ack_cycle("R6/R7 random ack");
      end else if (r < 19) begin
        end_of_irq();
        check_all("R9 random eoi");
      end else begin
        level_mode = $urandom % 2;
        do_init();
        check_all("R11 random init");
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule